// File: doc/BRIEF.md
# Pointer Register Address Generator

This block keeps three 16-bit pointer registers (X, Y and Z) and turns a memory access request into a data-memory address. A request names a pointer, an addressing mode and whether it is a load or a store. The block then drives the address together with a read or write strobe. When the mode asks for it, the block also steps the chosen pointer. The modes are:

- plain indirect, which uses the pointer as it is;
- post-increment, which uses the pointer and then adds one;
- pre-decrement, which subtracts one and then uses the result;
- displacement, which adds a small unsigned offset and is allowed only on Y and Z;
- direct, which passes a 16-bit immediate address through.

Every accepted request takes two clock cycles. In the first cycle the request is sampled and the address is computed. In the second cycle the address, the strobe, a done pulse and the pointer's resulting value are presented. A pointer that changes is written back at the end of that second cycle. A plain load port lets the surrounding datapath place a value into any pointer.

Top module: `ptr_agu`

## Requirements
- R1: After synchronous reset all three pointers read 0, and `rd_o`, `wr_o`, `done_o` and `illegal_o` are low.
- R2: Plain indirect mode (`mode_i`=0) drives `addr_o` equal to the selected pointer, and that pointer keeps its value.
- R3: Post-increment mode (`mode_i`=1) drives `addr_o` equal to the pointer before the step. The pointer then becomes its old value plus one, modulo 2^16, and `ptr_o` shows that new value.
- R4: Pre-decrement mode (`mode_i`=2) drives `addr_o` equal to the pointer minus one, modulo 2^16. The pointer takes that same value, and `ptr_o` equals `addr_o`.
- R5: Displacement mode (`mode_i`=3) on Y or Z drives `addr_o` = pointer + `disp_i`, with the 6-bit offset zero-extended and the sum taken modulo 2^16. The pointer is left unchanged.
- R6: Direct mode (`mode_i`=4) drives `addr_o` equal to `kaddr_i` for any `sel_i`. No pointer changes, and `ptr_o` reads 0.
- R7: A request is accepted when `start_i` is high on a clock edge while the block is idle. In the following cycle `done_o` pulses for one cycle. For a legal request exactly one strobe goes high in that same cycle: `rd_o` when `op_i`=0 (load) and `wr_o` when `op_i`=1 (store). Both operations support every mode.
- R8: Displacement mode on X, `sel_i`=3 with any mode other than direct, and `mode_i` values 5 to 7 are illegal. Such a request pulses `illegal_o` together with `done_o`, raises neither strobe, drives `addr_o` and `ptr_o` to 0, and changes no pointer.
- R9: `start_i` is ignored in the second cycle of an operation, so no two `done_o` pulses come in adjacent cycles.
- R10: Whenever `done_o` is low, `addr_o` and `ptr_o` are 0.
- R11: `sel_i` encodes 0=X, 1=Y, 2=Z. A high `ptr_wr_i` writes `ptr_wdata_i` into the pointer chosen by `ptr_wsel_i` at the next edge. On the same edge as a pointer write-back to that same pointer, the write-back wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe |
| op_i | input | 1 | 0 = load, 1 = store |
| sel_i | input | 2 | Pointer select: 0=X, 1=Y, 2=Z |
| mode_i | input | 3 | Addressing mode code |
| disp_i | input | 6 | Unsigned displacement |
| kaddr_i | input | 16 | Immediate address for direct mode |
| ptr_wr_i | input | 1 | Pointer load enable |
| ptr_wsel_i | input | 2 | Pointer chosen for load |
| ptr_wdata_i | input | 16 | Pointer load value |
| addr_o | output | 16 | Data-memory address |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| done_o | output | 1 | Operation completes this cycle |
| illegal_o | output | 1 | Request was illegal |
| ptr_o | output | 16 | Value the selected pointer holds after the operation |

## Verification
The following properties are checked on every cycle:
- the strobes never overlap;
- a strobe or the illegal flag never appears without `done_o`;
- every accepted start gives a done pulse one cycle later, and no two done pulses are adjacent;
- the outputs are idle-zero between operations;
- the address and pointer relations hold for post-increment, pre-decrement and direct modes.

Only the bench's sweeps can show the exact address of each mode and pointer, the wrap at 0 and 0xFFFF, and the offset limits. The same holds for the pointer state after each operation, which the bench reads back through plain loads. Load-port priority and the ignoring of a held start are also shown only by the bench.

// File: rtl/ptr_agu_pkg.sv
`timescale 1ns/1ps
package ptr_agu_pkg;

    typedef enum logic [2:0] {
        AM_PLAIN   = 3'd0,
        AM_POSTINC = 3'd1,
        AM_PREDEC  = 3'd2,
        AM_DISP    = 3'd3,
        AM_DIRECT  = 3'd4
    } amode_e;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } memop_e;

    // Mode codes above direct are undefined.
    function automatic logic mode_known(input logic [2:0] mode);
        return mode <= AM_DIRECT;
    endfunction

    // Modes that write a stepped value back to the pointer.
    function automatic logic mode_steps(input logic [2:0] mode);
        return (mode == AM_POSTINC) || (mode == AM_PREDEC);
    endfunction

endpackage

// File: rtl/ptr_agu_regs.sv
`timescale 1ns/1ps
module ptr_agu_regs #(
    parameter int AW   = 16,
    parameter int NPTR = 3,
    parameter int SW   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ld_en_i,
    input  logic [SW-1:0]            ld_sel_i,
    input  logic [AW-1:0]            ld_data_i,
    input  logic                     cm_en_i,
    input  logic [SW-1:0]            cm_sel_i,
    input  logic [AW-1:0]            cm_data_i,
    output logic [NPTR-1:0][AW-1:0]  ptrs_o
);

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        logic hit_cm;
        logic hit_ld;
        assign hit_cm = cm_en_i && (cm_sel_i == SW'(g));
        assign hit_ld = ld_en_i && (ld_sel_i == SW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ptrs_o[g] <= '0;
            end else if (hit_cm) begin
                ptrs_o[g] <= cm_data_i;
            end else if (hit_ld) begin
                ptrs_o[g] <= ld_data_i;
            end
        end
    end

endmodule

// File: rtl/ptr_agu_calc.sv
`timescale 1ns/1ps
module ptr_agu_calc
    import ptr_agu_pkg::*;
#(
    parameter int              AW      = 16,
    parameter int              QW      = 6,
    parameter int              NPTR    = 3,
    parameter int              SW      = 2,
    parameter logic [NPTR-1:0] DISP_OK = 3'b110
) (
    input  logic [2:0]               mode_i,
    input  logic [SW-1:0]            sel_i,
    input  logic [QW-1:0]            disp_i,
    input  logic [AW-1:0]            kaddr_i,
    input  logic [NPTR-1:0][AW-1:0]  ptrs_i,
    output logic [AW-1:0]            addr_o,
    output logic [AW-1:0]            nptr_o,
    output logic                     wb_o,
    output logic                     legal_o
);

    logic [AW-1:0] cur;
    logic          sel_ok;
    logic          disp_allowed;
    logic [AW-1:0] step_up;
    logic [AW-1:0] step_dn;
    logic [AW-1:0] with_disp;

    always_comb begin
        cur          = '0;
        disp_allowed = 1'b0;
        for (int i = 0; i < NPTR; i++) begin
            if (sel_i == SW'(i)) begin
                cur          = ptrs_i[i];
                disp_allowed = DISP_OK[i];
            end
        end
    end

    assign sel_ok    = sel_i < SW'(NPTR);
    assign step_up   = cur + AW'(1);
    assign step_dn   = cur - AW'(1);
    assign with_disp = cur + AW'(disp_i);

    always_comb begin
        addr_o = '0;
        nptr_o = '0;
        unique case (mode_i)
            AM_PLAIN: begin
                addr_o = cur;
                nptr_o = cur;
            end
            AM_POSTINC: begin
                addr_o = cur;
                nptr_o = step_up;
            end
            AM_PREDEC: begin
                addr_o = step_dn;
                nptr_o = step_dn;
            end
            AM_DISP: begin
                addr_o = with_disp;
                nptr_o = cur;
            end
            AM_DIRECT: begin
                addr_o = kaddr_i;
                nptr_o = '0;
            end
            default: begin
                addr_o = '0;
                nptr_o = '0;
            end
        endcase
    end

    always_comb begin
        if (!mode_known(mode_i)) begin
            legal_o = 1'b0;
        end else if (mode_i == AM_DIRECT) begin
            legal_o = 1'b1;
        end else if (!sel_ok) begin
            legal_o = 1'b0;
        end else if (mode_i == AM_DISP) begin
            legal_o = disp_allowed;
        end else begin
            legal_o = 1'b1;
        end
    end

    assign wb_o = legal_o && mode_steps(mode_i);

endmodule

// File: rtl/ptr_agu_seq.sv
`timescale 1ns/1ps
module ptr_agu_seq
    import ptr_agu_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic           op_i,
    input  logic [SW-1:0]  sel_i,
    input  logic           legal_i,
    input  logic           wb_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [AW-1:0]  nptr_i,
    output logic           busy_o,
    output logic [AW-1:0]  addr_o,
    output logic [AW-1:0]  ptr_o,
    output logic           rd_o,
    output logic           wr_o,
    output logic           done_o,
    output logic           illegal_o,
    output logic           cm_en_o,
    output logic [SW-1:0]  cm_sel_o
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] ptr;
        logic          rd;
        logic          wr;
        logic          done;
        logic          ill;
        logic          wb;
        logic [SW-1:0] sel;
    } rsp_t;

    rsp_t rsp_q;
    rsp_t rsp_d;
    logic accept;

    // A done pulse marks the second cycle; no new request is taken then.
    assign accept = start_i && !rsp_q.done;

    always_comb begin
        rsp_d = '0;
        if (accept) begin
            rsp_d.done = 1'b1;
            rsp_d.ill  = !legal_i;
            rsp_d.rd   = legal_i && (op_i == OP_LOAD);
            rsp_d.wr   = legal_i && (op_i == OP_STORE);
            rsp_d.addr = legal_i ? addr_i : '0;
            rsp_d.ptr  = legal_i ? nptr_i : '0;
            rsp_d.wb   = wb_i;
            rsp_d.sel  = sel_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign busy_o    = rsp_q.done;
    assign addr_o    = rsp_q.addr;
    assign ptr_o     = rsp_q.ptr;
    assign rd_o      = rsp_q.rd;
    assign wr_o      = rsp_q.wr;
    assign done_o    = rsp_q.done;
    assign illegal_o = rsp_q.ill;
    assign cm_en_o   = rsp_q.wb;
    assign cm_sel_o  = rsp_q.sel;

endmodule

// File: rtl/ptr_agu.sv
`timescale 1ns/1ps
module ptr_agu
    import ptr_agu_pkg::*;
#(
    parameter int              AW      = 16,
    parameter int              QW      = 6,
    parameter int              NPTR    = 3,
    parameter logic [NPTR-1:0] DISP_OK = 3'b110,
    localparam int             SW      = $clog2(NPTR + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic           op_i,
    input  logic [SW-1:0]  sel_i,
    input  logic [2:0]     mode_i,
    input  logic [QW-1:0]  disp_i,
    input  logic [AW-1:0]  kaddr_i,
    input  logic           ptr_wr_i,
    input  logic [SW-1:0]  ptr_wsel_i,
    input  logic [AW-1:0]  ptr_wdata_i,
    output logic [AW-1:0]  addr_o,
    output logic           rd_o,
    output logic           wr_o,
    output logic           done_o,
    output logic           illegal_o,
    output logic [AW-1:0]  ptr_o
);

    logic [NPTR-1:0][AW-1:0] ptrs;
    logic [AW-1:0]           calc_addr;
    logic [AW-1:0]           calc_nptr;
    logic                    calc_wb;
    logic                    calc_legal;
    logic                    busy;
    logic                    cm_en;
    logic [SW-1:0]           cm_sel;

    ptr_agu_regs #(.AW(AW), .NPTR(NPTR), .SW(SW)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .ld_en_i   (ptr_wr_i),
        .ld_sel_i  (ptr_wsel_i),
        .ld_data_i (ptr_wdata_i),
        .cm_en_i   (cm_en),
        .cm_sel_i  (cm_sel),
        .cm_data_i (ptr_o),
        .ptrs_o    (ptrs)
    );

    ptr_agu_calc #(
        .AW(AW), .QW(QW), .NPTR(NPTR), .SW(SW), .DISP_OK(DISP_OK)
    ) calc_i (
        .mode_i  (mode_i),
        .sel_i   (sel_i),
        .disp_i  (disp_i),
        .kaddr_i (kaddr_i),
        .ptrs_i  (ptrs),
        .addr_o  (calc_addr),
        .nptr_o  (calc_nptr),
        .wb_o    (calc_wb),
        .legal_o (calc_legal)
    );

    ptr_agu_seq #(.AW(AW), .SW(SW)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .op_i      (op_i),
        .sel_i     (sel_i),
        .legal_i   (calc_legal),
        .wb_i      (calc_wb),
        .addr_i    (calc_addr),
        .nptr_i    (calc_nptr),
        .busy_o    (busy),
        .addr_o    (addr_o),
        .ptr_o     (ptr_o),
        .rd_o      (rd_o),
        .wr_o      (wr_o),
        .done_o    (done_o),
        .illegal_o (illegal_o),
        .cm_en_o   (cm_en),
        .cm_sel_o  (cm_sel)
    );

endmodule

// File: rtl/ptr_agu_chk.sv
`timescale 1ns/1ps
module ptr_agu_chk #(
    parameter int AW = 16,
    parameter int SW = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           start_i,
    input logic           busy,
    input logic [SW-1:0]  sel_i,
    input logic [2:0]     mode_i,
    input logic [AW-1:0]  kaddr_i,
    input logic [AW-1:0]  addr_o,
    input logic [AW-1:0]  ptr_o,
    input logic           rd_o,
    input logic           wr_o,
    input logic           done_o,
    input logic           illegal_o
);

    logic accepted;
    assign accepted = start_i && !busy;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rd_o && wr_o)); // R7

    AST_STROBE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        (rd_o || wr_o || illegal_o) |-> done_o); // R7

    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
        accepted |=> done_o); // R7

    AST_NO_ADJACENT_DONE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R9

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!rd_o && !wr_o && addr_o == '0 && ptr_o == '0)); // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> (addr_o == '0 && ptr_o == '0)); // R10

    AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (rst)
        (accepted && mode_i == 3'd4) |=> (addr_o == $past(kaddr_i) && ptr_o == '0)); // R6

    AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (rst)
        (accepted && mode_i == 3'd1 && sel_i < SW'(3)) |=> (ptr_o == AW'(addr_o + 1'b1))); // R3

    AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (rst)
        (accepted && mode_i == 3'd2 && sel_i < SW'(3)) |=> (ptr_o == addr_o)); // R4

endmodule

bind ptr_agu ptr_agu_chk #(.AW(AW), .SW(SW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .busy      (busy),
    .sel_i     (sel_i),
    .mode_i    (mode_i),
    .kaddr_i   (kaddr_i),
    .addr_o    (addr_o),
    .ptr_o     (ptr_o),
    .rd_o      (rd_o),
    .wr_o      (wr_o),
    .done_o    (done_o),
    .illegal_o (illegal_o)
);

// File: tb/ptr_agu_tb_top.sv
`timescale 1ns/1ps
module ptr_agu_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        op_i = 1'b0;
    logic [1:0]  sel_i = '0;
    logic [2:0]  mode_i = '0;
    logic [5:0]  disp_i = '0;
    logic [15:0] kaddr_i = '0;
    logic        ptr_wr_i = 1'b0;
    logic [1:0]  ptr_wsel_i = '0;
    logic [15:0] ptr_wdata_i = '0;
    logic [15:0] addr_o;
    logic        rd_o;
    logic        wr_o;
    logic        done_o;
    logic        illegal_o;
    logic [15:0] ptr_o;

    int checks = 0;
    int failures = 0;
    logic [15:0] model [3];

    always #2 clk = ~clk;

    ptr_agu dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .sel_i(sel_i),
        .mode_i(mode_i), .disp_i(disp_i), .kaddr_i(kaddr_i),
        .ptr_wr_i(ptr_wr_i), .ptr_wsel_i(ptr_wsel_i), .ptr_wdata_i(ptr_wdata_i),
        .addr_o(addr_o), .rd_o(rd_o), .wr_o(wr_o), .done_o(done_o),
        .illegal_o(illegal_o), .ptr_o(ptr_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_ptr(input int idx, input logic [15:0] val);
        @(negedge clk);
        ptr_wr_i = 1'b1; ptr_wsel_i = 2'(idx); ptr_wdata_i = val;
        @(posedge clk);
        @(negedge clk);
        ptr_wr_i = 1'b0;
        model[idx] = val;
    endtask

    // Issue one request, check the done cycle, update the model after commit.
    task automatic run_op(input logic op, input int sel, input int mode,
                          input logic [5:0] q, input logic [15:0] k);
        logic        legal;
        logic [15:0] p, ea, np;
        string       req;
        p = (sel < 3) ? model[sel] : 16'h0;
        legal = (mode <= 4) && (mode == 4 || (sel < 3 && !(mode == 3 && sel == 0)));
        ea = 16'h0; np = 16'h0;
        case (mode)
            0: begin ea = p;                np = p;      req = "R2"; end
            1: begin ea = p;                np = p + 1;  req = "R3"; end
            2: begin ea = p - 1;            np = p - 1;  req = "R4"; end
            3: begin ea = p + 16'(q);       np = p;      req = "R5"; end
            4: begin ea = k;                np = 16'h0;  req = "R6"; end
            default: req = "R8";
        endcase
        if (!legal) begin ea = 16'h0; np = 16'h0; req = "R8"; end
        @(negedge clk);
        start_i = 1'b1; op_i = op; sel_i = 2'(sel); mode_i = 3'(mode);
        disp_i = q; kaddr_i = k;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check(req, {addr_o, ptr_o, rd_o, wr_o, done_o, illegal_o},
              {ea, np, legal && !op, legal && op, 1'b1, !legal});
        check("R7", {46'h0, done_o, rd_o, wr_o}, {46'h0, 1'b1, legal && !op, legal && op});
        @(posedge clk);
        if (legal && (mode == 1 || mode == 2)) model[sel] = np;
        @(negedge clk);
        check("R10", {addr_o, ptr_o, done_o, rd_o, wr_o, illegal_o}, 36'h0);
    endtask

    task automatic readback(input string req);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            start_i = 1'b1; op_i = 1'b0; sel_i = 2'(i); mode_i = 3'd0;
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            check(req, {48'h0, addr_o}, {48'h0, model[i]});
            @(posedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [15:0] seeds [4];
        logic [5:0]  qs [4];
        seeds[0] = 16'h0000; seeds[1] = 16'hFFFF; seeds[2] = 16'h8000; seeds[3] = 16'h12C1;
        qs[0] = 6'd0; qs[1] = 6'd63; qs[2] = 6'd1; qs[3] = 6'd37;
        for (int i = 0; i < 3; i++) model[i] = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet in reset, pointers zero after it
        check("R1", {addr_o, ptr_o, rd_o, wr_o, done_o, illegal_o}, 36'h0);
        rst = 1'b0;
        readback("R1");

        // Sweep every op, select and mode code over several pointer seeds.
        for (int s = 0; s < 4; s++) begin
            for (int op = 0; op < 2; op++) begin
                for (int sel = 0; sel < 4; sel++) begin
                    for (int m = 0; m < 8; m++) begin
                        load_ptr(0, seeds[s]);
                        load_ptr(1, seeds[s] ^ 16'h5A5A);
                        load_ptr(2, seeds[s] + 16'h0003);
                        run_op(op[0], sel, m, qs[(sel + m + s) % 4], seeds[s] ^ 16'hC3A5);
                        readback((m == 1) ? "R3" : (m == 2) ? "R4" : "R11");
                    end
                end
            end
        end

        // R9: start held through the second cycle is ignored.
        load_ptr(0, 16'h00FF);
        @(negedge clk);
        start_i = 1'b1; op_i = 1'b0; sel_i = 2'd0; mode_i = 3'd1;
        @(posedge clk);
        @(negedge clk);
        mode_i = 3'd4; kaddr_i = 16'hAAAA;
        check("R9", {63'h0, done_o}, 64'h1);
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check("R9", {61'h0, done_o, rd_o, wr_o}, 64'h0);
        model[0] = 16'h0100;
        readback("R9");

        // R11: commit to Y beats a load to Y on the same edge.
        load_ptr(1, 16'h4000);
        @(negedge clk);
        start_i = 1'b1; op_i = 1'b1; sel_i = 2'd1; mode_i = 3'd1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        ptr_wr_i = 1'b1; ptr_wsel_i = 2'd1; ptr_wdata_i = 16'hBEEF;
        @(posedge clk);
        @(negedge clk);
        ptr_wr_i = 1'b0;
        model[1] = 16'h4001;
        readback("R11");

        // R11: a load to Z on the commit edge of Y still lands.
        @(negedge clk);
        start_i = 1'b1; op_i = 1'b0; sel_i = 2'd1; mode_i = 3'd2;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        ptr_wr_i = 1'b1; ptr_wsel_i = 2'd2; ptr_wdata_i = 16'h7E57;
        @(posedge clk);
        @(negedge clk);
        ptr_wr_i = 1'b0;
        model[1] = 16'h4000;
        model[2] = 16'h7E57;
        readback("R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule